// File: doc/BRIEF.md
# Interrupt presentation controller

This unit sits between a layer of interrupt sources and one processor. It owns a single pending slot: the one interrupt currently offered to that processor. It drives the processor's level interrupt line while the slot is full. Sources offer an interrupt as a source number plus a priority. Numerically lower priorities are more favored. The unit either takes the offer into the slot or answers with a one-cycle reject pulse that carries the source number. When a more favored offer takes the slot, the source it displaces is bounced back to its source the same way.

Software reaches the unit through one operation port with five operations: write the processor's current priority, write the inter-processor request priority, accept (a destructive read), poll (a read with no side effects) and end-of-interrupt. The inter-processor request competes with external sources for the single slot and uses a fixed source number. Toward the source layer the unit emits reject, resend-request and end-of-interrupt-forward pulses, so that sources holding interrupts can offer them again.

Both inbound ports are valid/ready. The operation port is always ready. The offer port is back-pressured whenever an operation is presented in the same cycle, so at most one item is processed per clock and operations win. A stalled offer is not consumed and must be held until ready. Read results, the interrupt line and all pulses are registered and appear one clock after the item is taken.

Top module: `ipc_presenter`

## Requirements
- R1: After reset the interrupt line is low. A poll returns a status word of 0, whose fields are current priority [31:24] and pending source [23:0]. It returns an inter-processor request priority of 0xFF. A pending source of 0 means the slot is empty.
- R2: An offer is rejected when its priority is greater than or equal to the current priority. It is also rejected when the slot is full and the pending priority is less than or equal to the offer's priority. The rejection is a one-cycle `reject_valid` pulse with `reject_src` equal to the offered source, and the slot is unchanged.
- R3: An offer that is not rejected loads its source and priority into the slot and raises the interrupt line. If it displaces a pending external source, that source is rejected in the same cycle.
- R4: Operation code 2 (accept) returns the status word as it was before the operation and lowers the line. It then loads the current priority from the old pending priority, empties the slot and sets the pending priority to 0xFF.
- R5: Operation code 0 writes the current priority from `op_data[7:0]`. If the new value is more favored than the old one, the slot is full, and the new value is less than or equal to the pending priority, then the slot is emptied, the line is lowered, the pending priority returns to 0xFF, and a displaced external source is rejected.
- R6: An operation code 0 write of an equal or less favored value while the slot is empty triggers a resend.
- R7: Operation code 1 writes the inter-processor request priority from `op_data[7:0]`. If that value is below the current priority, the request installs source number 2 with that priority and raises the line. The exception is a pending entry whose priority is less than or equal to the request, which stays. A displaced external source is rejected. A displaced request entry is never rejected.
- R8: Operation code 4 (end-of-interrupt) loads the current priority from `op_data[31:24]`. It pulses `eoi_valid` with `eoi_src` = `op_data[23:0]`, and triggers a resend if the slot is empty.
- R9: A resend first performs the inter-processor check of R7 against the new current priority, then pulses `resend_req` for one cycle.
- R10: Operation code 3 (poll) returns the status word and the request priority and changes no state.
- R11: `op_ready` is always 1. `offer_ready` is 0 whenever `op_valid` is 1, and an offer that is not taken has no effect. All responses appear one clock after the operation or offer is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented |
| op_ready | output | 1 | Operation accepted (always 1) |
| op_code | input | 3 | 0 priority write, 1 request-priority write, 2 accept, 3 poll, 4 end-of-interrupt |
| op_data | input | SRC_W+PRIO_W | Operation write data |
| offer_valid | input | 1 | Source offer presented |
| offer_ready | output | 1 | Offer taken this cycle |
| offer_src | input | SRC_W | Offered source number (non-zero) |
| offer_prio | input | PRIO_W | Offered priority |
| rd_valid | output | 1 | Read result valid (accept or poll) |
| rd_word | output | SRC_W+PRIO_W | Status word: current priority and pending source |
| rd_ipi_prio | output | PRIO_W | Inter-processor request priority |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | Reject pulse toward the source layer |
| reject_src | output | SRC_W | Rejected source number |
| resend_req | output | 1 | Resend request pulse |
| eoi_valid | output | 1 | End-of-interrupt forward pulse |
| eoi_src | output | SRC_W | Forwarded source number |

## Verification
The bench builds the unit with its defaults: 24-bit source numbers, 8-bit priorities and request source number 2. Drawing priorities mostly from a small set that includes 0x00 and 0xFF makes ties between an offer, the current priority, the pending priority and the request priority frequent. That frequency exercises the greater-or-equal and less-or-equal boundaries of every rejection rule. Offers collide with operations in the same cycle often enough to exercise the back-pressure rule.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_SET_PRIO = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_POLL     = 3'd3,
    OP_EOI      = 3'd4
  } op_e;
endpackage

// File: rtl/ipc_offer_judge.sv
module ipc_offer_judge #(
  parameter int PRIO_W = 8
) (
  input  logic              slot_full,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              take
);
  // Offer must beat the processor priority and strictly beat any pending entry.
  always_comb begin
    take = (offer_prio < cur_prio) && !(slot_full && (pend_prio <= offer_prio));
  end
endmodule

// File: rtl/ipc_ipi_judge.sv
module ipc_ipi_judge #(
  parameter int PRIO_W = 8
) (
  input  logic              slot_full,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              install
);
  always_comb begin
    install = (req_prio < cur_prio) && !(slot_full && (pend_prio <= req_prio));
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] op_data,
  input  logic              offer_valid,
  output logic              offer_ready,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic [PRIO_W-1:0] rd_ipi_prio,
  output logic              irq_out,
  output logic              reject_valid,
  output logic [SRC_W-1:0]  reject_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src
);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  // Architectural state
  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              own_q, irq_q;
  logic [PRIO_W-1:0] cppr_d, pend_d, mfrr_d;
  logic [SRC_W-1:0]  xisr_d;
  logic              own_d, irq_d;

  // Registered responses
  logic              rej_v_d, rsnd_d, eoi_v_d, rd_v_d;
  logic [SRC_W-1:0]  rej_s_d, eoi_s_d;
  logic [WORD_W-1:0] rd_w_d;
  logic [PRIO_W-1:0] rd_m_d;

  op_e               op;
  logic              slot_full, op_fire, offer_fire;
  logic [PRIO_W-1:0] wr_prio, eoi_prio, judge_cur, judge_req;
  logic              offer_take, ipi_install;

  assign op       = op_e'(op_code);
  assign op_ready = 1'b1;
  assign offer_ready = !op_valid;
  assign op_fire    = op_valid;
  assign offer_fire = offer_valid && !op_valid;
  assign slot_full  = (xisr_q != '0);
  assign wr_prio    = op_data[PRIO_W-1:0];
  assign eoi_prio   = op_data[WORD_W-1:SRC_W];

  // The request check sees the priorities the current operation is about to establish.
  always_comb begin
    judge_req = (op_fire && op == OP_SET_IPI) ? wr_prio : mfrr_q;
    if (op_fire && op == OP_SET_PRIO)      judge_cur = wr_prio;
    else if (op_fire && op == OP_EOI)      judge_cur = eoi_prio;
    else                                   judge_cur = cppr_q;
  end

  ipc_offer_judge #(.PRIO_W(PRIO_W)) u_offer (
    .slot_full (slot_full),
    .cur_prio  (cppr_q),
    .pend_prio (pend_q),
    .offer_prio(offer_prio),
    .take      (offer_take)
  );

  ipc_ipi_judge #(.PRIO_W(PRIO_W)) u_ipi (
    .slot_full (slot_full),
    .cur_prio  (judge_cur),
    .pend_prio (pend_q),
    .req_prio  (judge_req),
    .install   (ipi_install)
  );

  always_comb begin
    cppr_d  = cppr_q;
    pend_d  = pend_q;
    mfrr_d  = mfrr_q;
    xisr_d  = xisr_q;
    own_d   = own_q;
    irq_d   = irq_q;
    rej_v_d = 1'b0;
    rej_s_d = '0;
    rsnd_d  = 1'b0;
    eoi_v_d = 1'b0;
    eoi_s_d = '0;
    rd_v_d  = 1'b0;
    rd_w_d  = '0;
    rd_m_d  = '0;
    if (op_fire) begin
      case (op)
        OP_SET_PRIO: begin
          cppr_d = wr_prio;
          if (wr_prio < cppr_q) begin
            if (slot_full && (wr_prio <= pend_q)) begin
              xisr_d = '0;
              pend_d = PRIO_IDLE;
              irq_d  = 1'b0;
              own_d  = 1'b0;
              if (own_q) begin
                rej_v_d = 1'b1;
                rej_s_d = xisr_q;
              end
            end
          end else if (!slot_full) begin
            rsnd_d = 1'b1;
            if (ipi_install) begin
              xisr_d = IPI_NUM;
              pend_d = mfrr_q;
              own_d  = 1'b0;
              irq_d  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_d = wr_prio;
          if (ipi_install) begin
            if (slot_full && own_q) begin
              rej_v_d = 1'b1;
              rej_s_d = xisr_q;
            end
            xisr_d = IPI_NUM;
            pend_d = wr_prio;
            own_d  = 1'b0;
            irq_d  = 1'b1;
          end
        end
        OP_ACCEPT: begin
          rd_v_d = 1'b1;
          rd_w_d = {cppr_q, xisr_q};
          rd_m_d = mfrr_q;
          cppr_d = pend_q;
          xisr_d = '0;
          pend_d = PRIO_IDLE;
          own_d  = 1'b0;
          irq_d  = 1'b0;
        end
        OP_POLL: begin
          rd_v_d = 1'b1;
          rd_w_d = {cppr_q, xisr_q};
          rd_m_d = mfrr_q;
        end
        OP_EOI: begin
          cppr_d  = eoi_prio;
          eoi_v_d = 1'b1;
          eoi_s_d = op_data[SRC_W-1:0];
          if (!slot_full) begin
            rsnd_d = 1'b1;
            if (ipi_install) begin
              xisr_d = IPI_NUM;
              pend_d = mfrr_q;
              own_d  = 1'b0;
              irq_d  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (offer_fire) begin
      if (offer_take) begin
        if (slot_full && own_q) begin
          rej_v_d = 1'b1;
          rej_s_d = xisr_q;
        end
        xisr_d = offer_src;
        pend_d = offer_prio;
        own_d  = 1'b1;
        irq_d  = 1'b1;
      end else begin
        rej_v_d = 1'b1;
        rej_s_d = offer_src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q       <= '0;
      xisr_q       <= '0;
      pend_q       <= PRIO_IDLE;
      mfrr_q       <= PRIO_IDLE;
      own_q        <= 1'b0;
      irq_q        <= 1'b0;
      reject_valid <= 1'b0;
      reject_src   <= '0;
      resend_req   <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      rd_valid     <= 1'b0;
      rd_word      <= '0;
      rd_ipi_prio  <= '0;
    end else begin
      cppr_q       <= cppr_d;
      xisr_q       <= xisr_d;
      pend_q       <= pend_d;
      mfrr_q       <= mfrr_d;
      own_q        <= own_d;
      irq_q        <= irq_d;
      reject_valid <= rej_v_d;
      reject_src   <= rej_s_d;
      resend_req   <= rsnd_d;
      eoi_valid    <= eoi_v_d;
      eoi_src      <= eoi_s_d;
      rd_valid     <= rd_v_d;
      rd_word      <= rd_w_d;
      rd_ipi_prio  <= rd_m_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/ipc_presenter_chk.sv
module ipc_presenter_chk #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [WORD_W-1:0] op_data,
  input logic              offer_valid,
  input logic              offer_ready,
  input logic [SRC_W-1:0]  offer_src,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              rd_valid,
  input logic              irq_out,
  input logic              reject_valid,
  input logic [SRC_W-1:0]  reject_src,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_src,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [SRC_W-1:0]  xisr_q
);
  assert_unfavored_offer_bounced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && offer_ready && (offer_prio >= cppr_q))
      |=> (reject_valid && (reject_src == $past(offer_src))));

  assert_line_matches_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  assert_accept_drops_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> (!irq_out && rd_valid && (xisr_q == '0)));

  assert_eoi_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4)
      |=> (eoi_valid && (eoi_src == $past(op_data[SRC_W-1:0]))));

  assert_poll_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3)
      |=> ($stable(xisr_q) && $stable(cppr_q) && $stable(irq_out) && !reject_valid));

  assert_offer_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !offer_ready);
endmodule

bind ipc_presenter ipc_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .op_data     (op_data),
  .offer_valid (offer_valid),
  .offer_ready (offer_ready),
  .offer_src   (offer_src),
  .offer_prio  (offer_prio),
  .rd_valid    (rd_valid),
  .irq_out     (irq_out),
  .reject_valid(reject_valid),
  .reject_src  (reject_src),
  .eoi_valid   (eoi_valid),
  .eoi_src     (eoi_src),
  .cppr_q      (cppr_q),
  .xisr_q      (xisr_q)
);

// File: tb/tb_ipc_presenter.sv
`timescale 1ns/1ps
module tb_ipc_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_data = '0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi_prio;
  logic        irq_out, reject_valid, resend_req, eoi_valid;
  logic [23:0] reject_src, eoi_src;

  always #10 clk = ~clk;

  ipc_presenter dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_data(op_data), .offer_valid(offer_valid),
    .offer_ready(offer_ready), .offer_src(offer_src), .offer_prio(offer_prio),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi_prio(rd_ipi_prio),
    .irq_out(irq_out), .reject_valid(reject_valid), .reject_src(reject_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements
  logic [7:0]  m_cppr, m_pp, m_mfrr;
  logic [23:0] m_xisr;
  bit          m_own, m_irq;
  bit          e_rv, e_rsnd, e_ev, e_rdv;
  logic [23:0] e_rs, e_es;
  logic [31:0] e_rdw;
  logic [7:0]  e_rdm;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic m_ipi_check();
    if (!(m_xisr != 0 && m_pp <= m_mfrr)) begin
      if (m_xisr != 0 && m_own) begin
        e_rv = 1; e_rs = m_xisr;
      end
      m_xisr = 24'd2; m_pp = m_mfrr; m_own = 0; m_irq = 1;
    end
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_ipi_check();
    e_rsnd = 1;
  endtask

  task automatic model(input bit ov, input logic [2:0] oc, input logic [31:0] od,
                       input bit fv, input logic [23:0] fs, input logic [7:0] fp);
    logic [7:0] c;
    e_rv = 0; e_rs = 0; e_rsnd = 0; e_ev = 0; e_es = 0; e_rdv = 0; e_rdw = 0; e_rdm = 0;
    if (ov) begin
      case (oc)
        3'd0: begin
          c = od[7:0];
          if (c < m_cppr) begin
            m_cppr = c;
            if (m_xisr != 0 && c <= m_pp) begin
              if (m_own) begin e_rv = 1; e_rs = m_xisr; end
              m_xisr = 0; m_pp = 8'hFF; m_own = 0; m_irq = 0;
            end
          end else begin
            m_cppr = c;
            if (m_xisr == 0) m_resend();
          end
        end
        3'd1: begin
          m_mfrr = od[7:0];
          if (m_mfrr < m_cppr) m_ipi_check();
        end
        3'd2: begin
          e_rdv = 1; e_rdw = {m_cppr, m_xisr}; e_rdm = m_mfrr;
          m_irq = 0; m_cppr = m_pp; m_xisr = 0; m_pp = 8'hFF; m_own = 0;
        end
        3'd3: begin
          e_rdv = 1; e_rdw = {m_cppr, m_xisr}; e_rdm = m_mfrr;
        end
        3'd4: begin
          m_cppr = od[31:24]; e_ev = 1; e_es = od[23:0];
          if (m_xisr == 0) m_resend();
        end
        default: ;
      endcase
    end else if (fv) begin
      if (fp >= m_cppr || (m_xisr != 0 && m_pp <= fp)) begin
        e_rv = 1; e_rs = fs;
      end else begin
        if (m_xisr != 0 && m_own) begin e_rv = 1; e_rs = m_xisr; end
        m_xisr = fs; m_pp = fp; m_own = 1; m_irq = 1;
      end
    end
  endtask

  task automatic step(input string tag, input bit ov, input logic [2:0] oc, input logic [31:0] od,
                      input bit fv, input logic [23:0] fs, input logic [7:0] fp);
    op_valid = ov; op_code = oc; op_data = od;
    offer_valid = fv; offer_src = fs; offer_prio = fp;
    model(ov, oc, od, fv, fs, fp);
    #1;
    chk("R11", "op_ready", {31'd0, op_ready}, 32'd1);
    chk("R11", "offer_ready", {31'd0, offer_ready}, {31'd0, !ov});
    @(posedge clk); #1;
    chk(tag, "irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    chk(tag, "reject_valid", {31'd0, reject_valid}, {31'd0, e_rv});
    if (e_rv) chk(tag, "reject_src", {8'd0, reject_src}, {8'd0, e_rs});
    chk(tag, "resend_req", {31'd0, resend_req}, {31'd0, e_rsnd});
    chk(tag, "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_ev});
    if (e_ev) chk(tag, "eoi_src", {8'd0, eoi_src}, {8'd0, e_es});
    chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e_rdv});
    if (e_rdv) begin
      chk(tag, "rd_word", rd_word, e_rdw);
      chk(tag, "rd_ipi_prio", {24'd0, rd_ipi_prio}, {24'd0, e_rdm});
    end
    op_valid = 0; offer_valid = 0;
  endtask

  function automatic logic [7:0] rp();
    case ($urandom % 6)
      0: rp = 8'h00;
      1: rp = 8'h02;
      2: rp = 8'h04;
      3: rp = 8'h06;
      4: rp = 8'hFF;
      default: rp = 8'($urandom);
    endcase
  endfunction

  function automatic logic [23:0] rsrc();
    rsrc = 24'(16 + ($urandom % 200));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_cppr = 0; m_xisr = 0; m_pp = 8'hFF; m_mfrr = 8'hFF; m_own = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1", "irq_out after reset", {31'd0, irq_out}, 32'd0);
    // R1: reset state seen through a poll
    step("R1", 1, 3'd3, 32'd0, 0, 0, 0);
    // R6: less favored write with empty slot asks for resend
    step("R6", 1, 3'd0, 32'h0000_00FF, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 24'h000100, 8'd5);
    step("R2", 0, 0, 0, 1, 24'h000101, 8'd5);
    step("R3", 0, 0, 0, 1, 24'h000102, 8'd3);
    step("R4", 1, 3'd2, 32'd0, 0, 0, 0);
    step("R2", 0, 0, 0, 1, 24'h000104, 8'd3);
    step("R7", 1, 3'd1, 32'h0000_0001, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 24'h000103, 8'd0);
    step("R5", 1, 3'd0, 32'h0000_0000, 0, 0, 0);
    step("R9", 1, 3'd4, 32'hFF00_0103, 0, 0, 0);
    step("R10", 1, 3'd3, 32'd0, 1, 24'h000105, 8'd0);
    step("R10", 1, 3'd3, 32'd0, 0, 0, 0);
    step("R8", 1, 3'd4, 32'h0700_0055, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom % 10);
      case (k)
        0, 1, 2, 3: step("R3", 0, 0, 0, 1, rsrc(), rp());
        4: step("R5", 1, 3'd0, {24'd0, rp()}, 0, 0, 0);
        5: step("R7", 1, 3'd1, {24'd0, rp()}, 0, 0, 0);
        6: step("R4", 1, 3'd2, 32'd0, ($urandom % 2) == 1, rsrc(), rp());
        7: step("R10", 1, 3'd3, 32'd0, 0, 0, 0);
        8: step("R8", 1, 3'd4, {rp(), rsrc()}, 0, 0, 0);
        default: step("R2", 0, 0, 0, 1, rsrc(), rp());
      endcase
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule